// File: doc/BRIEF.md
# Five-Stage Pseudo-Random Bit Sequence Generator

This block is a five-bit linear feedback shift register that produces a maximal-length pseudo-random bit stream of period 31, one bit for every clock on which the enable is high. It is meant for test-pattern generation, scrambling and similar jobs. In those uses a cheap, repeatable bit source matters more than statistical quality. A static parameter selects the feedback polarity, either exclusive-OR or exclusive-NOR. Each polarity has exactly one state that the register can never leave, and the block keeps the register out of it.

Software or a neighbouring block can replace the running state at any time by presenting a value together with a valid strobe. If that value is the forbidden lock-up state, a fixed legal seed is loaded in its place. A sticky flag records that this substitution took place. The flag is also set if the running state is ever found in the lock-up value, and in that case the next enabled clock reloads the legal seed.

The most recently loaded value, from reset or from a seed load, serves as a reference. A one-cycle wrap pulse marks every return of the register to that reference, so the sequence period appears as 31 enabled clocks between pulses.

Top module: `prbs5_gen`

## Requirements
- R1: A clock with `rst` high loads `state_out` with the default seed (parameter, 5'h01 by default) and clears `wrap` and `recovered`.
- R2: `rst` overrides `seed_valid` and `en` when they are high in the same cycle.
- R3: On an enabled clock with no reset and no seed load, `state_out[4:1]` takes the old `state_out[3:0]`, and `state_out[0]` takes old bit 4 XOR old bit 2 (XOR build) or the inverse of that (XNOR build).
- R4: `bit_out` always equals `state_out[4]`.
- R5: With `en`, `seed_valid` and `rst` low, `state_out` holds its value and `wrap` is low.
- R6: `seed_valid` high loads `seed_data` into `state_out` on the next clock, whatever `en` is, and that value becomes the wrap reference.
- R7: A seed equal to the lock-up value (5'h00 for XOR, 5'h1F for XNOR) loads the default seed instead, and `recovered` goes high on the same clock.
- R8: After a load, 31 enabled clocks visit 31 distinct states. `wrap` is high for exactly the one cycle in which `state_out` has just returned to the reference through an enabled shift.
- R9: Once set, `recovered` stays high until the next reset.
- R10: After reset, `state_out` never equals the lock-up value of the selected polarity.
- R11: In the XOR build, the serial stream contains runs of at most five consecutive ones and at most four consecutive zeros, and both of those lengths occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the register by one step |
| seed_valid | input | 1 | Load `seed_data` on this clock |
| seed_data | input | 5 | Value to load |
| bit_out | output | 1 | Serial pseudo-random bit (stage 5) |
| state_out | output | 5 | Parallel register contents |
| wrap | output | 1 | One-cycle pulse when the state returns to the reference |
| recovered | output | 1 | Sticky flag: a lock-up value was rejected or escaped |

## Verification
The bench builds two copies of the block from the same stimulus: one with XOR feedback and one with XNOR feedback, both using the default seed of 5'h01. Running both polarities side by side means a single seed of 5'h00 is rejected by one copy and accepted by the other, and 5'h1F does the reverse. This exercises both lock-up values and the sticky flag in each direction. The XOR copy also runs two full periods, which exposes the period length, the distinctness of states, the wrap timing and the run-length bounds.

// File: rtl/prbs5_pkg.sv
package prbs5_pkg;
    localparam int unsigned LEN   = 5;
    localparam int unsigned TAP_A = LEN - 1;   // stage 5
    localparam int unsigned TAP_B = 2;         // stage 3

    typedef logic [LEN-1:0] lfsr_t;

    typedef struct packed {
        lfsr_t st;
        lfsr_t ref_v;
        logic  wrap;
        logic  rec;
    } prbs_regs_t;

    function automatic lfsr_t lock_value(input bit xnor_fb);
        return xnor_fb ? {LEN{1'b1}} : {LEN{1'b0}};
    endfunction
endpackage

// File: rtl/prbs5_feedback.sv
module prbs5_feedback
    import prbs5_pkg::*;
#(
    parameter bit XNOR_FB = 1'b0
) (
    input  lfsr_t cur,
    output lfsr_t nxt
);
    logic fb;

    generate
        if (XNOR_FB) begin : g_xnor
            assign fb = ~(cur[TAP_A] ^ cur[TAP_B]);
        end else begin : g_xor
            assign fb = cur[TAP_A] ^ cur[TAP_B];
        end
    endgenerate

    assign nxt = {cur[LEN-2:0], fb};
endmodule

// File: rtl/prbs5_lock_detect.sv
module prbs5_lock_detect
    import prbs5_pkg::*;
#(
    parameter bit XNOR_FB = 1'b0
) (
    input  lfsr_t cur,
    input  lfsr_t seed,
    output logic  cur_locked,
    output logic  seed_locked
);
    localparam lfsr_t LOCK = lock_value(XNOR_FB);

    assign cur_locked  = (cur  == LOCK);
    assign seed_locked = (seed == LOCK);
endmodule

// File: rtl/prbs5_gen.sv
module prbs5_gen
    import prbs5_pkg::*;
#(
    parameter bit    XNOR_FB      = 1'b0,
    parameter lfsr_t DEFAULT_SEED = 5'h01
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           seed_valid,
    input  logic [LEN-1:0] seed_data,
    output logic           bit_out,
    output logic [LEN-1:0] state_out,
    output logic           wrap,
    output logic           recovered
);
    prbs_regs_t r_d, r_q;
    lfsr_t      shifted;
    logic       cur_locked, seed_locked;

    prbs5_feedback #(.XNOR_FB(XNOR_FB)) u_fb (
        .cur (r_q.st),
        .nxt (shifted)
    );

    prbs5_lock_detect #(.XNOR_FB(XNOR_FB)) u_lock (
        .cur         (r_q.st),
        .seed        (seed_data),
        .cur_locked  (cur_locked),
        .seed_locked (seed_locked)
    );

    always_comb begin
        r_d      = r_q;
        r_d.wrap = 1'b0;
        if (rst) begin
            r_d.st    = DEFAULT_SEED;
            r_d.ref_v = DEFAULT_SEED;
            r_d.rec   = 1'b0;
        end else if (seed_valid) begin
            if (seed_locked) begin
                r_d.st    = DEFAULT_SEED;
                r_d.ref_v = DEFAULT_SEED;
                r_d.rec   = 1'b1;
            end else begin
                r_d.st    = seed_data;
                r_d.ref_v = seed_data;
            end
        end else if (en) begin
            if (cur_locked) begin
                r_d.st  = DEFAULT_SEED;
                r_d.rec = 1'b1;
            end else begin
                r_d.st  = shifted;
            end
            r_d.wrap = (r_d.st == r_q.ref_v);
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_out = r_q.st;
    assign bit_out   = r_q.st[TAP_A];
    assign wrap      = r_q.wrap;
    assign recovered = r_q.rec;
endmodule

// File: rtl/prbs5_checker.sv
module prbs5_checker
    import prbs5_pkg::*;
#(
    parameter bit    XNOR_FB      = 1'b0,
    parameter lfsr_t DEFAULT_SEED = 5'h01
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic           seed_valid,
    input logic [LEN-1:0] seed_data,
    input logic           bit_out,
    input logic [LEN-1:0] state_out,
    input logic           wrap,
    input logic           recovered
);
    localparam lfsr_t LOCK = lock_value(XNOR_FB);

    // R1 and R2: reset wins over every other input
    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> (state_out == DEFAULT_SEED) && !wrap && !recovered);

    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_valid && state_out != LOCK) |=>
        (state_out[LEN-1:1] == $past(state_out[LEN-2:0])) &&
        (state_out[0] == ($past(state_out[TAP_A] ^ state_out[TAP_B]) ^ XNOR_FB)));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!en && !seed_valid) |=> $stable(state_out) && !wrap);

    p_seed_load_r6: assert property (@(posedge clk) disable iff (rst)
        (seed_valid && seed_data != LOCK) |=> state_out == $past(seed_data));

    p_seed_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (seed_valid && seed_data == LOCK) |=> (state_out == DEFAULT_SEED) && recovered);

    p_wrap_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap);

    p_rec_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        recovered |=> recovered);

    p_no_lock_r10: assert property (@(posedge clk) disable iff (rst)
        (state_out != LOCK) |=> (state_out != LOCK));
endmodule

bind prbs5_gen prbs5_checker #(
    .XNOR_FB      (XNOR_FB),
    .DEFAULT_SEED (DEFAULT_SEED)
) u_chk (.*);

// File: tb/sim_prbs5_gen.sv
`timescale 1ns/1ps
module sim_prbs5_gen;
    logic       clk = 1'b0;
    logic       rst_i = 1'b1, en_i = 1'b0, sv_i = 1'b0;
    logic [4:0] seed_i = 5'h00;
    logic       b_o [2];
    logic [4:0] s_o [2];
    logic       w_o [2];
    logic       r_o [2];

    int checks = 0, fails = 0;
    bit done = 0;
    int m_s [2], m_ref [2], m_w [2], m_rec [2];

    always #2 clk = ~clk;   // 250 MHz

    prbs5_gen #(.XNOR_FB(1'b0)) u0 (
        .clk(clk), .rst(rst_i), .en(en_i), .seed_valid(sv_i), .seed_data(seed_i),
        .bit_out(b_o[0]), .state_out(s_o[0]), .wrap(w_o[0]), .recovered(r_o[0]));
    prbs5_gen #(.XNOR_FB(1'b1)) u1 (
        .clk(clk), .rst(rst_i), .en(en_i), .seed_valid(sv_i), .seed_data(seed_i),
        .bit_out(b_o[1]), .state_out(s_o[1]), .wrap(w_o[1]), .recovered(r_o[1]));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lockv(input int k);
        return (k == 0) ? 0 : 31;
    endfunction

    task automatic model(input int k, input logic r, e, v, input logic [4:0] sd);
        int fb;
        if (r) begin
            m_s[k] = 1; m_ref[k] = 1; m_w[k] = 0; m_rec[k] = 0;
        end else if (v) begin
            m_w[k] = 0;
            if (int'(sd) == lockv(k)) begin m_s[k] = 1; m_rec[k] = 1; end
            else m_s[k] = int'(sd);
            m_ref[k] = m_s[k];
        end else if (e) begin
            if (m_s[k] == lockv(k)) begin m_s[k] = 1; m_rec[k] = 1; end
            else begin
                fb = ((m_s[k] / 16) % 2 + (m_s[k] / 4) % 2) % 2;
                if (k == 1) fb = 1 - fb;
                m_s[k] = (m_s[k] * 2) % 32 + fb;
            end
            m_w[k] = (m_s[k] == m_ref[k]) ? 1 : 0;
        end else begin
            m_w[k] = 0;
        end
    endtask

    task automatic step(input logic r, e, v, input logic [4:0] sd, input string tag);
        rst_i = r; en_i = e; sv_i = v; seed_i = sd;
        @(posedge clk);
        for (int k = 0; k < 2; k++) model(k, r, e, v, sd);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(int'(s_o[k]) == m_s[k], $sformatf("%s inst%0d state", tag, k), s_o[k], m_s[k]);
            chk(int'(b_o[k]) == (m_s[k] / 16) % 2, $sformatf("R4 inst%0d bit_out", k), b_o[k], (m_s[k] / 16) % 2);
            chk(int'(w_o[k]) == m_w[k], $sformatf("R8 inst%0d wrap", k), w_o[k], m_w[k]);
            chk(int'(r_o[k]) == m_rec[k], $sformatf("R9 inst%0d recovered", k), r_o[k], m_rec[k]);
            chk(int'(s_o[k]) != lockv(k), $sformatf("R10 inst%0d lock state", k), s_o[k], lockv(k));
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        bit seen [32];
        int distinct, wraps, run1, run0, max1, max0;
        @(negedge clk);
        // R1 R2: reset with seed load and enable also high
        step(1, 1, 1, 5'h0A, "R2");
        step(1, 1, 1, 5'h0A, "R1");
        chk(s_o[0] == 5'h01, "R1 reset seed xor", s_o[0], 1);
        chk(s_o[1] == 5'h01, "R1 reset seed xnor", s_o[1], 1);

        // R3 R8 R11: two full periods
        distinct = 0; wraps = 0; run1 = 0; run0 = 0; max1 = 0; max0 = 0;
        for (int i = 0; i < 32; i++) seen[i] = 0;
        for (int i = 1; i <= 62; i++) begin
            if (b_o[0]) begin run1++; run0 = 0; end else begin run0++; run1 = 0; end
            if (run1 > max1) max1 = run1;
            if (run0 > max0) max0 = run0;
            step(0, 1, 0, 5'h00, "R3");
            if (i <= 31 && !seen[s_o[0]]) begin seen[s_o[0]] = 1; distinct++; end
            if (w_o[0]) begin
                wraps++;
                chk(i == 31 || i == 62, "R8 wrap position", i, 31);
            end
        end
        chk(distinct == 31, "R8 distinct states", distinct, 31);
        chk(wraps == 2, "R8 wrap count", wraps, 2);
        chk(max1 == 5, "R11 longest ones run", max1, 5);
        chk(max0 == 4, "R11 longest zeros run", max0, 4);

        // R5: hold
        for (int i = 0; i < 4; i++) step(0, 0, 0, 5'h1F, "R5");

        // R6: seed load overrides enable, then a full period back to it
        step(0, 1, 1, 5'h15, "R6");
        chk(s_o[0] == 5'h15 && s_o[1] == 5'h15, "R6 seed loaded", s_o[0], 5'h15);
        wraps = 0;
        for (int i = 1; i <= 31; i++) begin
            step(0, 1, 0, 5'h00, "R6");
            if (w_o[0]) wraps++;
        end
        chk(wraps == 1 && w_o[0] == 1'b1, "R8 wrap after seed", wraps, 1);

        // R7 R9: lock-up seeds for each polarity
        step(0, 0, 1, 5'h00, "R7");
        chk(r_o[0] == 1'b1 && r_o[1] == 1'b0, "R7 zero seed flags", {r_o[0], r_o[1]}, 2);
        step(0, 1, 0, 5'h00, "R7");
        step(0, 0, 1, 5'h1F, "R7");
        chk(s_o[1] == 5'h01 && r_o[1] == 1'b1, "R7 ones seed xnor", s_o[1], 1);
        step(0, 0, 1, 5'h0C, "R9");
        for (int i = 0; i < 5; i++) step(0, 1, 0, 5'h00, "R9");
        chk(r_o[0] == 1'b1 && r_o[1] == 1'b1, "R9 flag sticky", {r_o[0], r_o[1]}, 3);
        step(1, 0, 0, 5'h00, "R1");
        chk(r_o[0] == 1'b0 && r_o[1] == 1'b0, "R1 flag cleared", {r_o[0], r_o[1]}, 0);
        for (int i = 0; i < 10; i++) step(0, i % 3 != 0, 0, 5'h00, "R3");

        done = 1;
        summary();
        $finish;
    end
endmodule